// File: doc/BRIEF.md
# Phase Frequency Detector with Programmable Antibacklash Overlap

This block compares the phase of a divided reference clock against a divided feedback clock. It produces the two steering pulses for a charge pump: `up_o` asks for a higher loop frequency and `dn_o` asks for a lower one. The design runs on a fast sampling clock. Each divided input is passed through a synchroniser, and only its rising edges are used. A rising edge on the reference side sets the up-state flop, and a rising edge on the feedback side sets the down-state flop.

Once both flops are set, a shared clear resets them together. The clear does not happen at once. It waits for a number of fast-clock cycles chosen by a 2-bit select. Because of this wait, both outputs always overlap for at least a programmed minimum width, even when the two inputs are exactly in phase. This overlap removes the dead zone of the detector's transfer function. The overlap width is captured only while both outputs are low, so a pulse that is already running keeps the width it started with.

Top module: `pfd_antibacklash`

## Requirements
- R1: While `rst_n` is low at a clock edge, both outputs are low after that edge.
- R2: A rising edge of `ref_div_i` first sampled high at clock edge k, after being sampled low at edge k-1, drives `up_o` high from edge k+2 onward.
- R3: A rising edge of `fb_div_i` first sampled high at clock edge k, after being sampled low at edge k-1, drives `dn_o` high from edge k+2 onward.
- R4: An output that is high while the other output is low stays high.
- R5: Once both outputs are high, they stay high together for exactly 2×(c+1) cycles and then fall in the same cycle. Here c is the unsigned value of `dly_sel_i`: code 0 gives 2 cycles, code 1 gives 4, code 2 gives 6 and code 3 gives 8.
- R6: Rising edges on both inputs at the same sampling edge raise both outputs in the same cycle, and they form one overlap pulse of the programmed width.
- R7: A rising edge on an input whose output is already high has no effect. This includes an edge that lands in the cycle of the clear: the output neither lengthens nor sets again after the clear.
- R8: `dly_sel_i` is taken only at edges where both outputs are low. A change of the select while either output is high does not alter the width of that pulse.
- R9: `up_o` and `dn_o` never fall in different cycles. Each output falls only in the shared clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Fast sampling clock |
| rst_n | input | 1 | Synchronous reset, active low |
| ref_div_i | input | 1 | Divided reference clock, asynchronous |
| fb_div_i | input | 1 | Divided feedback clock, asynchronous |
| dly_sel_i | input | 2 | Overlap width code, width is 2×(code+1) cycles |
| up_o | output | 1 | Up pulse to the charge pump |
| dn_o | output | 1 | Down pulse to the charge pump |

## Verification
Two events can fall on the same clock edge: the shared clear at the end of an overlap pulse, and a new rising edge arriving on one of the inputs. The clear has priority, so the edge is lost and the output must not set again. The same applies to the two set events landing together at zero phase error. The bench provokes both coincidences with directed sequences, where the edges are timed against each programmed width. It also provokes them through random toggling with the select changing every cycle. Every cycle is judged against a cycle-level model of the requirements, and the bench checks that the two outputs fall only together.

// File: rtl/pfd_pkg.sv
// Package: shared types and helpers for the phase frequency detector.
// Assumes the overlap code is always two bits wide.
package pfd_pkg;

    typedef logic [1:0] dly_code_t;

    // Number of fast-clock cycles the overlap lasts for a given code.
    function automatic int unsigned overlap_cycles(input dly_code_t code,
                                                   input int unsigned step);
        return step * (int'(code) + 1);
    endfunction

endpackage

// File: rtl/pfd_edge_sync.sv
// Module: pfd_edge_sync
// Synchronises one asynchronous divided clock into the fast clock domain
// and emits a one-cycle pulse for each rising edge it sees.
// Assumes the input stays high or low for at least two fast-clock cycles.
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic rise_o
);

    logic [STAGES:0] pipe_q;

    // Shift the input through the synchroniser chain and one history stage.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= {pipe_q[STAGES-1:0], din};
        end
    end

    // A rising edge is a synchronised high that follows a low.
    always_comb begin
        rise_o = pipe_q[STAGES-1] & ~pipe_q[STAGES];
    end

endmodule

// File: rtl/pfd_state_flop.sv
// Module: pfd_state_flop
// One detector state flop. A rise pulse sets it and the shared clear
// resets it. The clear wins over a rise in the same cycle.
// Assumes clr_i is asserted only while this flop is set.
module pfd_state_flop (
    input  logic clk,
    input  logic rst_n,
    input  logic rise_i,
    input  logic clr_i,
    output logic q_o
);

    // Hold the state; clear has priority, and a rise while set changes nothing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q_o <= 1'b0;
        end else if (clr_i) begin
            q_o <= 1'b0;
        end else if (rise_i) begin
            q_o <= 1'b1;
        end
    end

endmodule

// File: rtl/pfd_abl_timer.sv
// Module: pfd_abl_timer
// Antibacklash timer. While both state flops are set it counts cycles,
// and it asserts the shared clear on the last cycle of the programmed
// overlap. The overlap code is captured only while both flops are low.
// Assumes up_i and dn_i come straight from the state flops.
module pfd_abl_timer
    import pfd_pkg::*;
#(
    parameter int DLY_STEP = 2,
    parameter int CNT_W    = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      up_i,
    input  logic      dn_i,
    input  dly_code_t sel_i,
    output logic      clr_o
);

    dly_code_t        sel_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last_cnt;
    logic             both;

    // Decode the terminal count from the captured code.
    always_comb begin
        both     = up_i & dn_i;
        last_cnt = CNT_W'(overlap_cycles(sel_q, DLY_STEP) - 1);
        clr_o    = both && (cnt_q == last_cnt);
    end

    // Capture the code while idle and count the overlap cycles.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= '0;
            cnt_q <= '0;
        end else begin
            if (!up_i && !dn_i) begin
                sel_q <= sel_i;
            end
            if (both && !clr_o) begin
                cnt_q <= cnt_q + 1'b1;
            end else begin
                cnt_q <= '0;
            end
        end
    end

endmodule

// File: rtl/pfd_antibacklash.sv
// Module: pfd_antibacklash (top)
// Phase frequency detector with a programmable overlap delay in the
// shared clear path. Channel 0 is the reference side and drives up_o.
// Channel 1 is the feedback side and drives dn_o.
// Assumes both divided clocks are much slower than clk.
module pfd_antibacklash
    import pfd_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int DLY_STEP    = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_div_i,
    input  logic       fb_div_i,
    input  logic [1:0] dly_sel_i,
    output logic       up_o,
    output logic       dn_o
);

    localparam int NUM_CH = 2;
    localparam int MAX_OV = DLY_STEP * 4;
    localparam int CNT_W  = $clog2(MAX_OV + 1);

    logic [NUM_CH-1:0] ch_in;
    logic [NUM_CH-1:0] ch_rise;
    logic [NUM_CH-1:0] ch_q;
    logic              clr;

    // Gather the channel inputs and fan out the channel states.
    always_comb begin
        ch_in = {fb_div_i, ref_div_i};
        up_o  = ch_q[0];
        dn_o  = ch_q[1];
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .din   (ch_in[g]),
            .rise_o(ch_rise[g])
        );
        pfd_state_flop u_flop (
            .clk   (clk),
            .rst_n (rst_n),
            .rise_i(ch_rise[g]),
            .clr_i (clr),
            .q_o   (ch_q[g])
        );
    end

    pfd_abl_timer #(.DLY_STEP(DLY_STEP), .CNT_W(CNT_W)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .up_i (ch_q[0]),
        .dn_i (ch_q[1]),
        .sel_i(dly_sel_i),
        .clr_o(clr)
    );

endmodule

// File: rtl/pfd_antibacklash_chk.sv
// Module: pfd_antibacklash_chk
// Property checker bound to the detector top. It watches only the ports.
module pfd_antibacklash_chk #(
    parameter int DLY_STEP = 2
) (
    input logic       clk,
    input logic       rst_n,
    input logic       ref_div_i,
    input logic       fb_div_i,
    input logic [1:0] dly_sel_i,
    input logic       up_o,
    input logic       dn_o
);

    logic [1:0] sel_seen;
    logic [7:0] ov_len;

    // Track the code seen while idle and the length of the current overlap.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_seen <= '0;
            ov_len   <= '0;
        end else begin
            if (!up_o && !dn_o) sel_seen <= dly_sel_i;
            ov_len <= (up_o && dn_o) ? ov_len + 8'd1 : 8'd0;
        end
    end

    // R1
    reset_low_chk: assert property (@(posedge clk)
        !rst_n |=> (!up_o && !dn_o));

    // R4
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up_o && !dn_o) |=> up_o);

    // R4
    dn_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (dn_o && !up_o) |=> dn_o);

    // R9
    joint_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(up_o) || $fell(dn_o)) |-> ($fell(up_o) && $fell(dn_o)));

    // R5
    overlap_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(up_o) |-> (ov_len == 8'(DLY_STEP * (int'(sel_seen) + 1))));

endmodule

bind pfd_antibacklash pfd_antibacklash_chk #(.DLY_STEP(DLY_STEP)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .ref_div_i(ref_div_i),
    .fb_div_i (fb_div_i),
    .dly_sel_i(dly_sel_i),
    .up_o     (up_o),
    .dn_o     (dn_o)
);

// File: tb/pfd_antibacklash_bench.sv
`timescale 1ns/1ps
// Bench: directed corner cases plus seeded random toggling, compared
// every cycle against a cycle-level model built from the requirements.
module pfd_antibacklash_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_div = 1'b0;
    logic       fb_div = 1'b0;
    logic [1:0] dly_sel = 2'd0;
    logic       up_o;
    logic       dn_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    // Model state: history of sampled inputs, [0] is the newest sample.
    logic [3:0] hr = '0;
    logic [3:0] hf = '0;
    logic       m_up = 1'b0;
    logic       m_dn = 1'b0;
    int         m_cnt = 0;
    int         m_lim = 2;
    logic       prev_up = 1'b0;
    logic       prev_dn = 1'b0;

    always #2.5 clk = ~clk;

    pfd_antibacklash u_pfd_antibacklash (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_div_i(ref_div),
        .fb_div_i (fb_div),
        .dly_sel_i(dly_sel),
        .up_o     (up_o),
        .dn_o     (dn_o)
    );

    // Overlap width from R5.
    function automatic int width_of(input logic [1:0] c);
        return 2 * (int'(c) + 1);
    endfunction

    // Advance the model by one clock edge.
    task automatic model_step();
        logic both;
        logic idle;
        if (!rst_n) begin
            hr = '0; hf = '0; m_up = 1'b0; m_dn = 1'b0; m_cnt = 0; m_lim = 2;
        end else begin
            hr = {hr[2:0], ref_div};
            hf = {hf[2:0], fb_div};
            both = m_up && m_dn;
            idle = !m_up && !m_dn;
            if (both && m_cnt == m_lim - 1) begin
                m_up = 1'b0; m_dn = 1'b0; m_cnt = 0;
            end else begin
                if (both) m_cnt++;
                if (hr[2] && !hr[3]) m_up = 1'b1;
                if (hf[2] && !hf[3]) m_dn = 1'b1;
            end
            if (idle) m_lim = width_of(dly_sel);
        end
    endtask

    // Compare outputs against the model and check joint falling.
    task automatic compare(input string tag);
        checks++;
        if (up_o !== m_up || dn_o !== m_dn) begin
            fails++;
            $display("FAIL %s: up/dn actual %b%b expected %b%b at %0t",
                     tag, up_o, dn_o, m_up, m_dn, $time);
        end
        if ((prev_up && !up_o) || (prev_dn && !dn_o)) begin
            checks++;
            if ((prev_up && up_o) || (prev_dn && dn_o)) begin
                fails++;
                $display("FAIL R9: up/dn actual %b%b expected 00 at %0t",
                         up_o, dn_o, $time);
            end
        end
        prev_up = up_o;
        prev_dn = dn_o;
    endtask

    // Drive one cycle of inputs at the falling edge and check the result.
    task automatic cyc(input logic r, input logic f, input logic [1:0] s,
                       input string tag);
        ref_div = r; fb_div = f; dly_sel = s;
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare(tag);
    endtask

    task automatic hold(input int n, input logic r, input logic f,
                        input logic [1:0] s, input string tag);
        for (int i = 0; i < n; i++) cyc(r, f, s, tag);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        // R1: reset holds outputs low
        hold(4, 1'b0, 1'b0, 2'd0, "R1");
        rst_n = 1'b1;
        hold(3, 1'b0, 1'b0, 2'd0, "R1");

        // R2: reference edge latency, then R4 hold alone
        hold(3, 1'b1, 1'b0, 2'd0, "R2");
        hold(10, 1'b1, 1'b0, 2'd0, "R4");
        // R3: feedback edge sets down, then R5 overlap with code 0
        hold(3, 1'b1, 1'b1, 2'd0, "R3");
        hold(10, 1'b1, 1'b1, 2'd0, "R5");
        hold(4, 1'b0, 1'b0, 2'd1, "R5");
        // R3 alone then R5 with code 1
        hold(8, 1'b0, 1'b1, 2'd1, "R3");
        hold(12, 1'b1, 1'b1, 2'd1, "R5");
        hold(4, 1'b0, 1'b0, 2'd1, "R5");

        // R6: zero phase error for every code
        for (int c = 0; c < 4; c++) begin
            hold(14, 1'b1, 1'b1, 2'(c), "R6");
            hold(3, 1'b0, 1'b0, 2'(c), "R6");
        end

        // R7: extra reference edges while up is set, then clear collision
        hold(4, 1'b1, 1'b0, 2'd0, "R7");
        for (int k = 0; k < 3; k++) begin
            hold(2, 1'b0, 1'b0, 2'd0, "R7");
            hold(2, 1'b1, 1'b0, 2'd0, "R7");
        end
        hold(4, 1'b1, 1'b1, 2'd0, "R7");
        hold(2, 1'b0, 1'b1, 2'd0, "R7");
        hold(6, 1'b1, 1'b1, 2'd0, "R7");
        hold(4, 1'b0, 1'b0, 2'd0, "R7");
        // R7: new edges landing at the clear edge for code 2
        hold(3, 1'b1, 1'b1, 2'd2, "R7");
        hold(4, 1'b1, 1'b1, 2'd2, "R7");
        hold(2, 1'b0, 1'b0, 2'd2, "R7");
        hold(8, 1'b1, 1'b1, 2'd2, "R7");
        hold(3, 1'b0, 1'b0, 2'd2, "R7");

        // R8: change the code mid-pulse
        hold(3, 1'b1, 1'b1, 2'd3, "R8");
        hold(12, 1'b1, 1'b1, 2'd0, "R8");
        hold(3, 1'b0, 1'b0, 2'd0, "R8");
        hold(3, 1'b1, 1'b0, 2'd0, "R8");
        hold(4, 1'b1, 1'b0, 2'd3, "R8");
        hold(12, 1'b1, 1'b1, 2'd3, "R8");
        hold(3, 1'b0, 1'b0, 2'd2, "R8");

        // Random toggling with the code changing freely
        for (int i = 0; i < 4000; i++) begin
            logic r;
            logic f;
            r = ref_div;
            f = fb_div;
            if ($urandom_range(0, 5) == 0) r = ~r;
            if ($urandom_range(0, 5) == 0) f = ~f;
            cyc(r, f, 2'($urandom_range(0, 3)), "R7 random");
        end

        done = 1'b1;
        finish_run();
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R1 watchdog: actual running expected finished");
            finish_run();
        end
    end

endmodule